// File: doc/BRIEF.md
# Paired Indirect Dual-ALU Executor

This block carries out the two-result arithmetic and bitwise instructions of a small 8-bit machine. It keeps four source index registers and two destination index registers. Each index register holds a byte address into a 256-byte data memory. An instruction byte picks one destination index and two source indices. From those picks the block forms two operand pairs: the selected pair, and the pair one position further on, where the position wraps around. It fetches all four operands through the index registers, computes a primary result and a dual result, and writes both results back to the addresses held in the two destination registers.

The memory sits outside the block behind a single port with a synchronous read, so the block makes exactly one access per cycle. A caller first loads the index registers through a small load port. It then pulses `start` with an instruction byte and waits for the one-cycle `done` pulse. Instruction fetch and register rotation belong to other blocks.

Top module: `bdx_dual_exec`

## Requirements
- R1: The instruction byte is decoded as follows: bits 7..5 are the opcode, bit 4 is the destination select D, bits 3..2 are the first source select S1, and bits 1..0 are the second source select S2. Opcode 001 is the arithmetic instruction and opcode 010 is the bitwise instruction.
- R2: For the arithmetic instruction, the byte at address dst[D] becomes M[src[S1]] + M[src[S2]], modulo 256.
- R3: For the arithmetic instruction, the byte at address dst[(D+1) mod 2] becomes M[src[(S1+1) mod 4]] - M[src[(S2+1) mod 4]], modulo 256.
- R4: For the bitwise instruction, dst[D] receives the AND of M[src[S1]] and M[src[S2]], and dst[(D+1) mod 2] receives the XOR of M[src[(S1+1) mod 4]] and M[src[(S2+1) mod 4]].
- R5: The four operands are read in this order: src[S1], src[S2], src[S1+1], src[S2+1]. All four reads finish before the first write, so a write never changes an operand of the same instruction.
- R6: The dual result is written first and the primary result second. When both destination addresses are equal, the primary result is the value that remains.
- R7: A start accepted while idle gives reads in cycles 1 to 4 after the accepting edge, the dual write in cycle 6, the primary write in cycle 7, and a `done` pulse lasting one cycle in cycle 8. No cycle has both a read and a write.
- R8: A start with any opcode other than 001 or 010 makes no memory access and raises `done` in the cycle after acceptance.
- R9: While `busy` is high, `start` and register loads are ignored.
- R10: Reset leaves the block idle, with `busy`, `done`, `mem_re` and `mem_we` low and all six index registers at zero.
- R11: A load with `ld_en` high while idle writes `ld_val` into one register: select codes 0..3 pick source registers 0..3, and codes 4 and 5 pick destination registers 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| instr | input | 8 | Instruction byte |
| ld_en | input | 1 | Index register load strobe |
| ld_sel | input | 3 | Index register select for a load |
| ld_val | input | 8 | Value to load |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Memory read request; data is returned the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench sets S1 to 3 so that the partner index must wrap to 0, and it chooses operands that make the sum overflow and the difference borrow. A design that failed to wrap would read a fifth, undefined register, and a design that sign-extended or saturated would write the wrong byte. It points both destination registers at one address; a design that swapped the write order would leave the dual result there in place of the primary one. It also makes a destination equal to an operand's address, and starts and loads a register while the block is busy; a design that interleaved reads and writes, or took the second start or the load, would produce values or write counts that differ from the expected ones. Unsupported opcodes are checked for exactly one cycle of latency and no memory traffic, and the first run after reset relies on every register reading back as zero.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

    localparam int OPC_W = 3;
    localparam logic [OPC_W-1:0] OPC_ARITH = 3'b001;
    localparam logic [OPC_W-1:0] OPC_BITW  = 3'b010;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_RD0  = 4'd1,
        ST_RD1  = 4'd2,
        ST_RD2  = 4'd3,
        ST_RD3  = 4'd4,
        ST_CAP  = 4'd5,
        ST_WRD  = 4'd6,
        ST_WRP  = 4'd7,
        ST_FIN  = 4'd8
    } seq_state_e;

    typedef enum logic {
        ALU_ARITH = 1'b0,
        ALU_BITW  = 1'b1
    } alu_mode_e;

    function automatic logic opc_supported(input logic [OPC_W-1:0] opc);
        return (opc == OPC_ARITH) || (opc == OPC_BITW);
    endfunction

endpackage

// File: rtl/bdx_idx_regs.sv
module bdx_idx_regs #(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 2,
    parameter int AW      = 8,
    parameter int SEL_W   = $clog2(NUM_SRC + NUM_DST)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic [SEL_W-1:0]              ld_sel,
    input  logic [AW-1:0]                 ld_val,
    output logic [NUM_SRC-1:0][AW-1:0]    src_idx,
    output logic [NUM_DST-1:0][AW-1:0]    dst_idx
);

    // Source index registers occupy select codes 0 .. NUM_SRC-1.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [AW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (ld_en && (ld_sel == SEL_W'(g))) begin
                val_d = ld_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign src_idx[g] = val_q;
    end

    // Destination index registers follow the source registers in select space.
    for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
        logic [AW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (ld_en && (ld_sel == SEL_W'(NUM_SRC + g))) begin
                val_d = ld_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign dst_idx[g] = val_q;
    end

endmodule

// File: rtl/bdx_addr_sel.sv
module bdx_addr_sel #(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 2,
    parameter int AW      = 8,
    parameter int SIW     = $clog2(NUM_SRC),
    parameter int DIW     = $clog2(NUM_DST)
) (
    input  logic [NUM_SRC-1:0][AW-1:0] src_idx,
    input  logic [NUM_DST-1:0][AW-1:0] dst_idx,
    input  logic [SIW-1:0]             sel_s1,
    input  logic [SIW-1:0]             sel_s2,
    input  logic [DIW-1:0]             sel_d,
    input  logic [1:0]                 rd_slot,
    output logic [AW-1:0]              rd_addr,
    output logic [AW-1:0]              wr_pri_addr,
    output logic [AW-1:0]              wr_dual_addr
);

    // Partner index: one position further on, wrapping at the register count.
    function automatic logic [SIW-1:0] src_next(input logic [SIW-1:0] i);
        return (int'(i) == NUM_SRC - 1) ? '0 : SIW'(int'(i) + 1);
    endfunction

    function automatic logic [DIW-1:0] dst_next(input logic [DIW-1:0] i);
        return (int'(i) == NUM_DST - 1) ? '0 : DIW'(int'(i) + 1);
    endfunction

    logic [SIW-1:0] s1_nx, s2_nx;
    logic [DIW-1:0] d_nx;

    always_comb begin
        s1_nx = src_next(sel_s1);
        s2_nx = src_next(sel_s2);
        d_nx  = dst_next(sel_d);
    end

    // Read slot order: first pair, then partner pair.
    always_comb begin
        unique case (rd_slot)
            2'd0:    rd_addr = src_idx[sel_s1];
            2'd1:    rd_addr = src_idx[sel_s2];
            2'd2:    rd_addr = src_idx[s1_nx];
            default: rd_addr = src_idx[s2_nx];
        endcase
    end

    always_comb begin
        wr_pri_addr  = dst_idx[sel_d];
        wr_dual_addr = dst_idx[d_nx];
    end

endmodule

// File: rtl/bdx_dual_alu.sv
module bdx_dual_alu
    import bdx_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_mode_e     mode,
    input  logic [DW-1:0] pri_a,
    input  logic [DW-1:0] pri_b,
    input  logic [DW-1:0] dual_a,
    input  logic [DW-1:0] dual_b,
    output logic [DW-1:0] res_pri,
    output logic [DW-1:0] res_dual
);

    // Both lanes wrap at DW bits; the dual lane performs the opposite operation.
    always_comb begin
        unique case (mode)
            ALU_BITW: begin
                res_pri  = pri_a & pri_b;
                res_dual = dual_a ^ dual_b;
            end
            default: begin
                res_pri  = pri_a + pri_b;
                res_dual = dual_a - dual_b;
            end
        endcase
    end

endmodule

// File: rtl/bdx_dual_exec.sv
module bdx_dual_exec
    import bdx_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 2,
    parameter int DW      = 8,
    parameter int AW      = 8,
    parameter int SIW     = $clog2(NUM_SRC),
    parameter int DIW     = $clog2(NUM_DST),
    parameter int INSTR_W = OPC_W + DIW + 2 * SIW,
    parameter int SEL_W   = $clog2(NUM_SRC + NUM_DST)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic               ld_en,
    input  logic [SEL_W-1:0]   ld_sel,
    input  logic [AW-1:0]      ld_val,
    output logic               busy,
    output logic               done,
    output logic               mem_re,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata
);

    localparam int S2_LSB = 0;
    localparam int S1_LSB = SIW;
    localparam int D_LSB  = 2 * SIW;
    localparam int OPC_LSB = 2 * SIW + DIW;

    typedef struct packed {
        seq_state_e     st;
        alu_mode_e      mode;
        logic [SIW-1:0] s1;
        logic [SIW-1:0] s2;
        logic [DIW-1:0] d;
        logic [DW-1:0]  op_a;   // M[src[S1]]
        logic [DW-1:0]  op_b;   // M[src[S2]]
        logic [DW-1:0]  op_c;   // M[src[S1+1]]
        logic [DW-1:0]  op_e;   // M[src[S2+1]]
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUM_SRC-1:0][AW-1:0] src_idx;
    logic [NUM_DST-1:0][AW-1:0] dst_idx;
    logic [1:0]                 rd_slot;
    logic [AW-1:0]              rd_addr, wr_pri_addr, wr_dual_addr;
    logic [DW-1:0]              res_pri, res_dual;
    logic [OPC_W-1:0]           opc;
    logic                       idle;

    assign idle = (c_q.st == ST_IDLE);
    assign opc  = instr[OPC_LSB +: OPC_W];

    // Loads are only taken while idle so operands cannot shift mid-instruction.
    bdx_idx_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_DST (NUM_DST),
        .AW      (AW),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en && idle),
        .ld_sel  (ld_sel),
        .ld_val  (ld_val),
        .src_idx (src_idx),
        .dst_idx (dst_idx)
    );

    bdx_addr_sel #(
        .NUM_SRC (NUM_SRC),
        .NUM_DST (NUM_DST),
        .AW      (AW),
        .SIW     (SIW),
        .DIW     (DIW)
    ) u_addr (
        .src_idx      (src_idx),
        .dst_idx      (dst_idx),
        .sel_s1       (c_q.s1),
        .sel_s2       (c_q.s2),
        .sel_d        (c_q.d),
        .rd_slot      (rd_slot),
        .rd_addr      (rd_addr),
        .wr_pri_addr  (wr_pri_addr),
        .wr_dual_addr (wr_dual_addr)
    );

    bdx_dual_alu #(
        .DW (DW)
    ) u_alu (
        .mode     (c_q.mode),
        .pri_a    (c_q.op_a),
        .pri_b    (c_q.op_b),
        .dual_a   (c_q.op_c),
        .dual_b   (c_q.op_e),
        .res_pri  (res_pri),
        .res_dual (res_dual)
    );

    always_comb begin
        c_d       = c_q;
        rd_slot   = 2'd0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.s2 = instr[S2_LSB +: SIW];
                    c_d.s1 = instr[S1_LSB +: SIW];
                    c_d.d  = instr[D_LSB +: DIW];
                    if (opc_supported(opc)) begin
                        c_d.mode = (opc == OPC_BITW) ? ALU_BITW : ALU_ARITH;
                        c_d.st   = ST_RD0;
                    end else begin
                        c_d.st = ST_FIN;
                    end
                end
            end
            ST_RD0: begin
                rd_slot  = 2'd0;
                mem_re   = 1'b1;
                mem_addr = rd_addr;
                c_d.st   = ST_RD1;
            end
            ST_RD1: begin
                rd_slot  = 2'd1;
                mem_re   = 1'b1;
                mem_addr = rd_addr;
                c_d.op_a = mem_rdata;
                c_d.st   = ST_RD2;
            end
            ST_RD2: begin
                rd_slot  = 2'd2;
                mem_re   = 1'b1;
                mem_addr = rd_addr;
                c_d.op_b = mem_rdata;
                c_d.st   = ST_RD3;
            end
            ST_RD3: begin
                rd_slot  = 2'd3;
                mem_re   = 1'b1;
                mem_addr = rd_addr;
                c_d.op_c = mem_rdata;
                c_d.st   = ST_CAP;
            end
            ST_CAP: begin
                c_d.op_e = mem_rdata;
                c_d.st   = ST_WRD;
            end
            ST_WRD: begin
                mem_we    = 1'b1;
                mem_addr  = wr_dual_addr;
                mem_wdata = res_dual;
                c_d.st    = ST_WRP;
            end
            ST_WRP: begin
                mem_we    = 1'b1;
                mem_addr  = wr_pri_addr;
                mem_wdata = res_pri;
                c_d.st    = ST_FIN;
            end
            ST_FIN: begin
                c_d.st = ST_IDLE;
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = !idle;
    assign done = (c_q.st == ST_FIN);

endmodule

// File: rtl/bdx_dual_exec_chk.sv
module bdx_dual_exec_chk
    import bdx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OPC_W-1:0] opc,
    input logic             busy,
    input logic             done,
    input logic             mem_re,
    input logic             mem_we
);

    // R7: one memory access per cycle
    p_one_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a supported start begins reading in the next cycle
    p_start_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opc_supported(opc)) |=> (mem_re && busy));

    // R8: an unsupported opcode completes at once with no access
    p_bad_opc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !opc_supported(opc)) |=> (done && !mem_re && !mem_we));

    // R6: writes come as a back-to-back pair
    p_write_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> mem_we);

    // R7: done follows the second write
    p_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> done);

    // R10: no memory traffic while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !done));

endmodule

bind bdx_dual_exec bdx_dual_exec_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opc    (instr[INSTR_W-1 -: bdx_pkg::OPC_W]),
    .busy   (busy),
    .done   (done),
    .mem_re (mem_re),
    .mem_we (mem_we)
);

// File: tb/sim_bdx_dual_exec.sv
module sim_bdx_dual_exec;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] instr = 8'h00;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_val = 8'h00;
    logic       busy, done, mem_re, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;

    logic [7:0] mem [256];

    int total = 0;
    int bad = 0;
    int lat, rd_n, wr_n;
    logic [7:0] rd_log [8];
    logic [7:0] wr_log [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bdx_dual_exec u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .instr     (instr),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_val    (ld_val),
        .busy      (busy),
        .done      (done),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Single-port memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_reg(input int sel, input int val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'(sel); ld_val = 8'(val);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input int a, input int b, input int c, input int e,
                            input int d0, input int d1);
        load_reg(0, a); load_reg(1, b); load_reg(2, c); load_reg(3, e);
        load_reg(4, d0); load_reg(5, d1);
    endtask

    task automatic mem_clear();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic mem_example();
        mem_clear();
        mem[0] = 8'd2; mem[1] = 8'd3; mem[2] = 8'd5;
        mem[3] = 8'd7; mem[4] = 8'd11; mem[5] = 8'd13;
    endtask

    // Issue one instruction and trace the accesses until done.
    task automatic run(input logic [7:0] ins, input bit disturb);
        @(negedge clk);
        instr = ins; start = 1'b1;
        lat = 0; rd_n = 0; wr_n = 0;
        while (lat < 40) begin
            @(negedge clk);
            start = 1'b0; ld_en = 1'b0;
            lat++;
            if (mem_re) begin
                if (rd_n < 8) rd_log[rd_n] = mem_addr;
                rd_n++;
            end
            if (mem_we) begin
                if (wr_n < 8) wr_log[wr_n] = mem_addr;
                wr_n++;
            end
            if (disturb && lat == 2) begin
                start = 1'b1; instr = 8'h4D;
                ld_en = 1'b1; ld_sel = 3'd3; ld_val = 8'd99;
            end
            if (done) break;
        end
        check("R7 done reached", int'(done), 1);
    endtask

    task automatic t_reset();
        check("R10 busy after reset", int'(busy), 0);
        check("R10 done after reset", int'(done), 0);
        check("R10 mem_re after reset", int'(mem_re), 0);
        check("R10 mem_we after reset", int'(mem_we), 0);
        // All index registers zero: every access goes to address 0.
        mem_clear();
        mem[0] = 8'd7;
        run(8'h21, 1'b0);
        check("R10 zero regs read addr", int'(rd_log[3]), 0);
        check("R10 zero regs primary survives", int'(mem[0]), 14);
    endtask

    task automatic t_arith_example();
        load_all(0, 1, 2, 3, 4, 5);
        mem_example();
        run(8'h2D, 1'b0);   // opcode 001, D=0, S1=3, S2=1
        check("R2 primary sum", int'(mem[4]), 10);
        check("R3 dual difference with S1 wrap", int'(mem[5]), 253);
        check("R7 latency", lat, 8);
        check("R7 read count", rd_n, 4);
        check("R7 write count", wr_n, 2);
        check("R5 R1 read 0 addr", int'(rd_log[0]), 3);
        check("R5 R1 read 1 addr", int'(rd_log[1]), 1);
        check("R5 R1 read 2 addr", int'(rd_log[2]), 0);
        check("R5 R1 read 3 addr", int'(rd_log[3]), 2);
        check("R6 R11 first write is dual dst", int'(wr_log[0]), 5);
        check("R6 R11 second write is primary dst", int'(wr_log[1]), 4);
    endtask

    task automatic t_bitwise();
        load_all(0, 1, 2, 3, 4, 5);
        mem_example();
        run(8'h4D, 1'b0);   // opcode 010, D=0, S1=3, S2=1
        check("R4 primary AND", int'(mem[4]), 3);
        check("R4 dual XOR", int'(mem[5]), 7);
        check("R4 latency", lat, 8);
    endtask

    task automatic t_wrap();
        load_all(10, 20, 30, 40, 50, 60);
        mem_clear();
        mem[10] = 8'd30; mem[20] = 8'd77; mem[40] = 8'd250;
        run(8'h3C, 1'b0);   // opcode 001, D=1, S1=3, S2=0
        check("R2 overflow sum at dst[1]", int'(mem[60]), 24);
        check("R3 borrow difference at dst[0]", int'(mem[50]), 209);
        check("R3 partner of S1=3 is src0", int'(rd_log[2]), 10);
        check("R3 partner of S2=0 is src1", int'(rd_log[3]), 20);
        check("R1 D=1 dual write first to dst[0]", int'(wr_log[0]), 50);
    endtask

    task automatic t_same_dst();
        load_all(0, 1, 2, 3, 9, 9);
        mem_clear();
        mem[0] = 8'd5; mem[1] = 8'd6; mem[2] = 8'd7; mem[3] = 8'd8;
        run(8'h41, 1'b0);   // opcode 010, D=0, S1=0, S2=1
        check("R6 equal dst keeps primary", int'(mem[9]), 4);
    endtask

    task automatic t_overlap();
        load_all(0, 1, 2, 3, 1, 0);
        mem_clear();
        mem[0] = 8'd10; mem[1] = 8'd20; mem[2] = 8'd30; mem[3] = 8'd40;
        run(8'h21, 1'b0);   // opcode 001, D=0, S1=0, S2=1
        check("R5 dual into operand address", int'(mem[0]), 246);
        check("R5 primary uses original operand", int'(mem[1]), 30);
    endtask

    task automatic t_bad_opc();
        load_all(0, 1, 2, 3, 4, 5);
        mem_example();
        run(8'h0D, 1'b0);   // opcode 000
        check("R8 latency opcode 000", lat, 1);
        check("R8 no reads opcode 000", rd_n, 0);
        check("R8 no writes opcode 000", wr_n, 0);
        run(8'hED, 1'b0);   // opcode 111
        check("R8 latency opcode 111", lat, 1);
        check("R8 no writes opcode 111", wr_n, 0);
        check("R8 memory untouched", int'(mem[4]), 11);
    endtask

    task automatic t_busy();
        load_all(0, 1, 2, 3, 4, 5);
        mem_example();
        run(8'h2D, 1'b1);   // second start and a load arrive while busy
        check("R9 second start ignored, writes", wr_n, 2);
        check("R9 second start ignored, latency", lat, 8);
        check("R9 result from first instr", int'(mem[4]), 10);
        @(negedge clk);
        check("R9 idle after done", int'(busy), 0);
        mem_example();
        run(8'h2D, 1'b0);   // src3 must still point at address 3
        check("R9 load while busy ignored", int'(mem[4]), 10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mem_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith_example();
        t_bitwise();
        t_wrap();
        t_same_dst();
        t_overlap();
        t_bad_opc();
        t_busy();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule